// File: doc/BRIEF.md
# Power Management Timer and Event Status

This block keeps a free-running power management timer and a small status register with two event flags, both cleared by writing ones. One flag records bus master activity. The other flags that the timer's upper tap bit went high. The timer advances once for each cycle in which a tick-enable input is high. That input is meant to be a one-cycle pulse at the power management rate, 3.579545 MHz. With the default 24-bit width, the tap event repeats roughly every 2.34 seconds.

The timer event can raise a level interrupt. A routing control sends it to either the SCI output or the SMI output. The bus master flag never raises an interrupt. A read-as-zero control hides bus master activity that came from bus requests or from the request message. Activity from DMA or from an LPC-side master stays visible even while that control is set.

Top module: `pm_event_status`

## Requirements
- R1: The timer `tmr_val` increments by one on each clock edge where `tick_en` is 1, holds otherwise, and wraps from all ones to zero.
- R2: Status bit 0 (timer event) is set on the edge where timer bit `TAP_BIT` (default 22) goes from 0 to 1. It is not set when that bit falls or when the timer wraps to zero.
- R3: A write with `wr_data` bit 0 set clears status bit 0, and a write with bit 4 set clears status bit 4. A write carrying 0 in a flag's position leaves that flag unchanged.
- R4: When a hardware set and a software clear of the same flag fall on the same edge, the flag ends up set.
- R5: `sci_irq` or `smi_irq` is high while status bit 0 and `ovf_en` are both 1. It goes to `sci_irq` when `sci_sel` is 1 and to `smi_irq` when `sci_sel` is 0, and it drops once the flag is cleared. The two outputs are never high together.
- R6: Status bit 4 (bus master) is set when any bit of `ext_req` or `int_req` is 1 at a clock edge.
- R7: A `c2_msg` pulse sets status bit 4 only while `deep_cstate` is 1. Outside that state it has no effect.
- R8: While `bm_zero_en` is 1, activity from R6 and R7 reads as 0 in bit 4. Activity on `dma_req` always sets bit 4 and makes it read 1.
- R9: Bus master status never drives `sci_irq` or `smi_irq`.
- R10: After reset the timer and both flags are 0, both interrupts are low, and bits 7:5 and 3:1 of `stat_rd` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer advance pulse |
| ext_req | input | NUM_EXT | External bus master requests |
| int_req | input | 1 | Internal bus master request |
| dma_req | input | 1 | DMA or LPC bus master activity |
| deep_cstate | input | 1 | System is in C3 or C4 |
| c2_msg | input | 1 | Request message strobe |
| ovf_en | input | 1 | Timer event interrupt enable |
| sci_sel | input | 1 | Route timer interrupt to SCI (1) or SMI (0) |
| bm_zero_en | input | 1 | Bus master read-as-zero control |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 8 | Write data; ones clear flags |
| stat_rd | output | 8 | Status read value |
| tmr_val | output | TMR_W | Current timer value |
| sci_irq | output | 1 | SCI interrupt level |
| smi_irq | output | 1 | SMI interrupt level |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that `dma_req`, `ext_req` and the message strobe are sampled at the same edge as any write. They place no limit on how often `tick_en` fires. The stimulus changes every input only on the falling clock edge and holds it for whole cycles. A smaller timer width and tap position are used so that rising edges, falling edges and the wrap of the tap bit all occur within a short run.

// File: rtl/pm_event_status.sv
module pm_event_status #(
  parameter int TMR_W   = 24,
  parameter int TAP_BIT = 22,
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic [NUM_EXT-1:0] ext_req,
  input  logic               int_req,
  input  logic               dma_req,
  input  logic               deep_cstate,
  input  logic               c2_msg,
  input  logic               ovf_en,
  input  logic               sci_sel,
  input  logic               bm_zero_en,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  output logic [7:0]         stat_rd,
  output logic [TMR_W-1:0]   tmr_val,
  output logic               sci_irq,
  output logic               smi_irq
);

  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [TMR_W-1:0] tmr_q;
  logic ovf_sts, bm_gen, bm_dma;

  wire tap_rise = tick_en & ~tmr_q[TAP_BIT] & (&tmr_q[TAP_BIT-1:0]);
  wire gen_hit  = (|ext_req) | int_req | (c2_msg & deep_cstate);
  wire clr_ovf  = wr_en & wr_data[0];
  wire clr_bm   = wr_en & wr_data[4];
  wire bm_vis   = bm_dma | (bm_gen & ~bm_zero_en);
  wire ovf_irq  = ovf_sts & ovf_en;

  logic unused_wr;
  assign unused_wr = ^{wr_data[7:5], wr_data[3:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      ovf_sts <= 1'b0;
      bm_gen  <= 1'b0;
      bm_dma  <= 1'b0;
    end else begin
      if (tick_en) tmr_q <= tmr_q + ONE;
      if (tap_rise)     ovf_sts <= 1'b1;
      else if (clr_ovf) ovf_sts <= 1'b0;
      if (gen_hit)      bm_gen <= 1'b1;
      else if (clr_bm)  bm_gen <= 1'b0;
      if (dma_req)      bm_dma <= 1'b1;
      else if (clr_bm)  bm_dma <= 1'b0;
    end
  end

  assign tmr_val = tmr_q;
  assign stat_rd = {3'b000, bm_vis, 3'b000, ovf_sts};
  assign sci_irq = ovf_irq & sci_sel;
  assign smi_irq = ovf_irq & ~sci_sel;

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> tmr_val == $past(tmr_val) + ONE); // R1
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tmr_val)); // R1
  AST_TAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_val[TAP_BIT]) |-> stat_rd[0]); // R2
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0] && stat_rd[0]) |=> stat_rd[0]); // R3
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sci_irq, smi_irq})); // R5
  AST_DMA_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> stat_rd[4]); // R8
  AST_BM_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_rd[4]) && !stat_rd[0]) |-> !(sci_irq || smi_irq)); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[7:5] == 3'b000 && stat_rd[3:1] == 3'b000); // R10

endmodule

// File: tb/pm_event_status_tb.sv
module pm_event_status_tb_top;
  localparam int TW = 10, TAP = 8, NE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 0, int_req = 0, dma_req = 0, deep_cstate = 0, c2_msg = 0;
  logic ovf_en = 0, sci_sel = 0, bm_zero_en = 0, wr_en = 0;
  logic [NE-1:0] ext_req = '0;
  logic [7:0] wr_data = '0, stat_rd;
  logic [TW-1:0] tmr_val;
  logic sci_irq, smi_irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pm_event_status #(.TMR_W(TW), .TAP_BIT(TAP), .NUM_EXT(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_req(ext_req),
    .int_req(int_req), .dma_req(dma_req), .deep_cstate(deep_cstate),
    .c2_msg(c2_msg), .ovf_en(ovf_en), .sci_sel(sci_sel),
    .bm_zero_en(bm_zero_en), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .tmr_val(tmr_val), .sci_irq(sci_irq), .smi_irq(smi_irq));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R10 timer", int'(tmr_val), 0);
    chk("R10 status", int'(stat_rd), 0);
    chk("R10 irq", int'({sci_irq, smi_irq}), 0);
  endtask

  task automatic t_timer;
    ticks(255);
    chk("R1 count", int'(tmr_val), 255);
    chk("R2 no early set", int'(stat_rd[0]), 0);
    ticks(1);
    chk("R2 tap rise", int'(stat_rd), 8'h01);
    wr(8'hFE);
    chk("R3 zero write keeps", int'(stat_rd[0]), 1);
    wr(8'h01);
    chk("R3 clear", int'(stat_rd[0]), 0);
    ticks(256);
    chk("R2 tap fall no set", int'(stat_rd[0]), 0);
    repeat (3) @(negedge clk);
    chk("R1 hold", int'(tmr_val), 512);
    ticks(255);
    chk("R1 count 767", int'(tmr_val), 767);
    tick_en = 1; wr_en = 1; wr_data = 8'h01;
    @(negedge clk);
    tick_en = 0; wr_en = 0; wr_data = '0;
    chk("R4 set wins", int'(stat_rd[0]), 1);
    wr(8'h01);
    ticks(256);
    chk("R1 wrap", int'(tmr_val), 0);
    chk("R2 wrap no set", int'(stat_rd[0]), 0);
  endtask

  task automatic t_irq;
    ticks(256);
    chk("R5 disabled", int'({sci_irq, smi_irq}), 0);
    ovf_en = 1; sci_sel = 1; @(negedge clk);
    chk("R5 sci route", int'({sci_irq, smi_irq}), 2'b10);
    sci_sel = 0; @(negedge clk);
    chk("R5 smi route", int'({sci_irq, smi_irq}), 2'b01);
    wr(8'h01);
    chk("R5 drops on clear", int'({sci_irq, smi_irq}), 0);
  endtask

  task automatic t_bm;
    ext_req = 4'b0100; @(negedge clk); ext_req = '0;
    chk("R6 ext req", int'(stat_rd), 8'h10);
    chk("R9 no irq", int'({sci_irq, smi_irq}), 0);
    wr(8'hEF);
    chk("R3 bm keeps", int'(stat_rd[4]), 1);
    wr(8'h10);
    chk("R3 bm clear", int'(stat_rd[4]), 0);
    int_req = 1; wr_en = 1; wr_data = 8'h10; @(negedge clk);
    int_req = 0; wr_en = 0; wr_data = '0;
    chk("R6 R4 int req wins", int'(stat_rd[4]), 1);
    wr(8'h10);
    c2_msg = 1; @(negedge clk); c2_msg = 0;
    chk("R7 msg outside deep", int'(stat_rd[4]), 0);
    deep_cstate = 1; c2_msg = 1; @(negedge clk); c2_msg = 0; deep_cstate = 0;
    chk("R7 msg in deep", int'(stat_rd[4]), 1);
    wr(8'h10);
    bm_zero_en = 1;
    ext_req = 4'b0001; @(negedge clk); ext_req = '0;
    chk("R8 hidden", int'(stat_rd[4]), 0);
    dma_req = 1; @(negedge clk); dma_req = 0;
    chk("R8 dma visible", int'(stat_rd[4]), 1);
    wr(8'h10);
    bm_zero_en = 0; @(negedge clk);
    chk("R8 clear both", int'(stat_rd[4]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_irq();
    t_bm();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule